// File: doc/BRIEF.md
# Video Field Timing Counter with Vertical Sync Realignment

This block keeps line and field timing for a standard-definition video output path. It divides an enabled pixel clock into lines and lines into fields. Fields alternate between a long field and a short field: 263 and 262 lines in a 525-line system, 313 and 312 lines in a 625-line system. It reports the current line number, the field identifier, and one-cycle strobes at the start and at the end of each field.

Tape input played in fast-forward or rewind delivers vertical sync pulses that do not line up with the nominal field length. When realignment is enabled, the field boundary follows the incoming vertical sync. An early sync restarts the field at once. After a late sync's nominal count runs out, the counter parks on the last line until the sync arrives. The output therefore carries one field signal, never two that disagree. The park is bounded: after one extra field's worth of lines without a sync, the counter starts the next field by itself. Realignment is disabled in timing mode 0, even when the enable bit is set.

The incoming sync passes through a two-flop synchronizer. Its rising edge is taken as the sync event.

Top module: `fct_field_timer`

## Requirements
- R1: While reset is low, and at the first sample after reset is released, the outputs are line 0, field 0, and both strobes low.
- R2: The line number rises by one after each PIX enabled clocks. PIX is PIX_525 when std625_i is 0 and PIX_625 when it is 1. A clock with pix_en_i low advances nothing, and the line number never steps by more than one except back to 0.
- R3: Field 0 (field_o = 0) has the long length and field 1 has the short length. In 525-line mode (std625_i = 0) these are 263 and 262 lines. In 625-line mode they are 313 and 312 lines. field_o toggles at every field boundary, and line_o always stays below the current field's length.
- R4: With realignment inactive, a field ends only when its last line completes. eof_o and sof_o then pulse in the same cycle, and vsync_i has no effect.
- R5: Realignment is inactive when tmode_i is 2'b00, whatever resync_en_i is. It is active only when resync_en_i is 1 and tmode_i is not 2'b00.
- R6: With realignment active, a rising edge of vsync_i restarts the field at any line. Three clock edges after the edge that first samples vsync_i high, line_o is 0, field_o has toggled, sof_o is high, and the pixel phase restarts.
- R7: With realignment active, completing the last line pulses eof_o and parks line_o on the last line with no sof_o. The new field starts only on a sync edge, which then gives exactly one sof_o.
- R8: A park lasts at most the field's own length in line periods. If no sync arrives, the next field starts by itself, so each field then spans twice its nominal length.
- R9: sof_o is a single-cycle pulse that comes with line_o = 0 and a field_o toggle. field_o changes at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| pix_en_i | input | 1 | Pixel-rate enable |
| vsync_i | input | 1 | Incoming vertical sync (asynchronous) |
| resync_en_i | input | 1 | Enables realignment to the incoming vertical sync |
| tmode_i | input | 2 | Timing mode; 2'b00 is slave mode 0 |
| std625_i | input | 1 | 0 selects 525-line timing, 1 selects 625-line timing |
| line_o | output | LINE_W | Line number within the current field, counted from 0 |
| field_o | output | 1 | Field identifier |
| sof_o | output | 1 | Start-of-field strobe |
| eof_o | output | 1 | End-of-field strobe (nominal line count complete) |

## Verification
The assertions check these rules on every cycle:
- a start strobe always comes with line 0 and a field toggle, and the field bit is stable otherwise;
- the line number stays within the current field's length and steps by at most one;
- nothing advances while the pixel enable is low;
- an active sync edge restarts the field on the next cycle;
- with realignment inactive, the end strobe always coincides with a start strobe.

Only the bench's scenarios show the behaviour that depends on timing:
- the exact three-edge latency from the sync input;
- the park on the last line during a late sync, and its bounded timeout;
- that sync pulses in mode 0 leave the counting unchanged.

The bench runs each of these through a sweep of standard, mode, enable and pixel-enable gap patterns. It compares the outputs against line positions it computes arithmetically.

// File: rtl/fct_pkg.sv
// Package: shared types and decode for the field timing counter.
// Assumes the timing-mode encoding is fixed at 2 bits, with 0 meaning slave mode 0.
package fct_pkg;

    typedef enum logic [1:0] {
        TM_SLAVE0 = 2'd0,
        TM_SLAVE1 = 2'd1,
        TM_SLAVE2 = 2'd2,
        TM_MASTER = 2'd3
    } tmode_e;

    // Realignment is honoured only when enabled and not in slave mode 0.
    function automatic logic resync_active(input logic en, input logic [1:0] mode);
        return en && (mode != TM_SLAVE0);
    endfunction

endpackage

// File: rtl/fct_vsync_edge.sv
// Module: synchronizes the asynchronous vertical sync and gives a one-clock pulse
// on its rising edge.
// Assumes STAGES >= 2. The pulse comes STAGES edges after the first sampling edge
// and is valid for one clock.
module fct_vsync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic vsync_i,
    output logic rise_o
);

    logic [STAGES:0] shift_q;

    // Purpose: shift the sync through the synchronizer plus one history flop.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[STAGES-1:0], vsync_i};
        end
    end

    // Purpose: a rising edge is the newest synchronized level high and the previous level low.
    always_comb begin
        rise_o = shift_q[STAGES-1] & ~shift_q[STAGES];
    end

endmodule

// File: rtl/fct_line_pacer.sv
// Module: counts enabled pixel clocks and gives a line-advance pulse on the last pixel of a line.
// Assumes both line lengths are at least 2. A restart request puts the pixel phase back to 0.
module fct_line_pacer #(
    parameter int PIX_525 = 858,
    parameter int PIX_625 = 864,
    localparam int PIX_MAX = (PIX_525 > PIX_625) ? PIX_525 : PIX_625,
    localparam int PIX_W   = $clog2(PIX_MAX)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pix_en_i,
    input  logic std625_i,
    input  logic restart_i,
    output logic line_adv_o
);

    logic [PIX_W-1:0] pix_q;
    logic [PIX_W-1:0] pix_last;

    // Purpose: pick the last pixel index for the selected standard.
    always_comb begin
        pix_last   = std625_i ? PIX_W'(PIX_625 - 1) : PIX_W'(PIX_525 - 1);
        line_adv_o = pix_en_i && (pix_q == pix_last);
    end

    // Purpose: advance the pixel phase on enabled clocks and wrap at the line end.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pix_q <= '0;
        end else if (restart_i) begin
            pix_q <= '0;
        end else if (pix_en_i) begin
            pix_q <= (pix_q == pix_last) ? '0 : pix_q + PIX_W'(1);
        end
    end

endmodule

// File: rtl/fct_field_seq.sv
// Module: line and field sequencer. It counts lines, toggles the field at boundaries,
// parks on the last line while waiting for a late sync, and restarts on an early sync.
// Assumes LINE_W holds the longest field length. Field 0 uses the long length.
module fct_field_seq #(
    parameter int LONG_525  = 263,
    parameter int SHORT_525 = 262,
    parameter int LONG_625  = 313,
    parameter int SHORT_625 = 312,
    parameter int LINE_W    = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              std625_i,
    input  logic              rs_act_i,
    input  logic              sync_i,
    input  logic              line_adv_i,
    output logic [LINE_W-1:0] line_o,
    output logic              field_o,
    output logic              sof_o,
    output logic              eof_o
);

    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] hold_cnt_q;
    logic              hold_q;
    logic              field_q;
    logic              sof_q;
    logic              eof_q;
    logic [LINE_W-1:0] len_m1;
    logic              at_last;

    // Purpose: the last line index of the current field, for the selected standard.
    always_comb begin
        if (std625_i) begin
            len_m1 = field_q ? LINE_W'(SHORT_625 - 1) : LINE_W'(LONG_625 - 1);
        end else begin
            len_m1 = field_q ? LINE_W'(SHORT_525 - 1) : LINE_W'(LONG_525 - 1);
        end
        at_last = (line_q >= len_m1);
    end

    // Purpose: the line/field state machine, with the sync restart taking priority over counting.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            line_q     <= '0;
            hold_cnt_q <= '0;
            hold_q     <= 1'b0;
            field_q    <= 1'b0;
            sof_q      <= 1'b0;
            eof_q      <= 1'b0;
        end else begin
            sof_q <= 1'b0;
            eof_q <= 1'b0;
            if (rs_act_i && sync_i) begin
                line_q     <= '0;
                field_q    <= ~field_q;
                hold_q     <= 1'b0;
                hold_cnt_q <= '0;
                sof_q      <= 1'b1;
            end else if (line_adv_i) begin
                if (hold_q) begin
                    if (rs_act_i && (hold_cnt_q != len_m1)) begin
                        hold_cnt_q <= hold_cnt_q + LINE_W'(1);
                    end else begin
                        line_q     <= '0;
                        field_q    <= ~field_q;
                        hold_q     <= 1'b0;
                        hold_cnt_q <= '0;
                        sof_q      <= 1'b1;
                    end
                end else if (at_last) begin
                    eof_q <= 1'b1;
                    if (rs_act_i) begin
                        hold_q     <= 1'b1;
                        hold_cnt_q <= '0;
                    end else begin
                        line_q  <= '0;
                        field_q <= ~field_q;
                        sof_q   <= 1'b1;
                    end
                end else begin
                    line_q <= line_q + LINE_W'(1);
                end
            end
        end
    end

    assign line_o  = line_q;
    assign field_o = field_q;
    assign sof_o   = sof_q;
    assign eof_o   = eof_q;

endmodule

// File: rtl/fct_field_timer.sv
// Module: top of the field timing counter. It joins the sync edge detector, the
// pixel-to-line pacer and the line/field sequencer.
// Assumes vsync_i is asynchronous and all other inputs are synchronous to clk_i.
module fct_field_timer #(
    parameter int PIX_525     = 858,
    parameter int PIX_625     = 864,
    parameter int LONG_525    = 263,
    parameter int SHORT_525   = 262,
    parameter int LONG_625    = 313,
    parameter int SHORT_625   = 312,
    parameter int SYNC_STAGES = 2,
    parameter int LINE_W      = $clog2(LONG_625 + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pix_en_i,
    input  logic              vsync_i,
    input  logic              resync_en_i,
    input  logic [1:0]        tmode_i,
    input  logic              std625_i,
    output logic [LINE_W-1:0] line_o,
    output logic              field_o,
    output logic              sof_o,
    output logic              eof_o
);

    logic vs_rise;
    logic rs_act;
    logic restart;
    logic line_adv;

    // Purpose: decode whether realignment applies, and raise the restart request.
    always_comb begin
        rs_act  = fct_pkg::resync_active(resync_en_i, tmode_i);
        restart = rs_act && vs_rise;
    end

    fct_vsync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .vsync_i (vsync_i),
        .rise_o  (vs_rise)
    );

    fct_line_pacer #(.PIX_525(PIX_525), .PIX_625(PIX_625)) u_pacer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pix_en_i   (pix_en_i),
        .std625_i   (std625_i),
        .restart_i  (restart),
        .line_adv_o (line_adv)
    );

    fct_field_seq #(
        .LONG_525 (LONG_525),  .SHORT_525(SHORT_525),
        .LONG_625 (LONG_625),  .SHORT_625(SHORT_625),
        .LINE_W   (LINE_W)
    ) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .std625_i   (std625_i),
        .rs_act_i   (rs_act),
        .sync_i     (vs_rise),
        .line_adv_i (line_adv),
        .line_o     (line_o),
        .field_o    (field_o),
        .sof_o      (sof_o),
        .eof_o      (eof_o)
    );

endmodule

// File: rtl/fct_field_timer_chk.sv
// Module: assertion checker for fct_field_timer, attached by bind.
// Assumes the configuration inputs change only while reset is held.
module fct_field_timer_chk #(
    parameter int LONG_525  = 263,
    parameter int SHORT_525 = 262,
    parameter int LONG_625  = 313,
    parameter int SHORT_625 = 312,
    parameter int LINE_W    = 9
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              pix_en_i,
    input logic              resync_en_i,
    input logic [1:0]        tmode_i,
    input logic              std625_i,
    input logic              vs_rise_i,
    input logic [LINE_W-1:0] line_o,
    input logic              field_o,
    input logic              sof_o,
    input logic              eof_o
);

    logic              rs_on;
    logic [LINE_W:0]   cur_len;

    // Purpose: the realignment state and field length as seen from the ports.
    always_comb begin
        rs_on = resync_en_i && (tmode_i != 2'b00);
        if (std625_i) cur_len = field_o ? (LINE_W+1)'(SHORT_625) : (LINE_W+1)'(LONG_625);
        else          cur_len = field_o ? (LINE_W+1)'(SHORT_525) : (LINE_W+1)'(LONG_525);
    end

    assert_sof_marks_field_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sof_o |-> (line_o == '0) && (field_o != $past(field_o)));

    assert_field_only_at_sof_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sof_o |-> $stable(field_o));

    assert_line_in_field_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        {1'b0, line_o} < cur_len);

    assert_line_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sof_o |-> ({1'b0, line_o} == {1'b0, $past(line_o)}) ||
                   ({1'b0, line_o} == {1'b0, $past(line_o)} + 1'b1));

    assert_freeze_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pix_en_i && !vs_rise_i) |=> $stable(line_o) && $stable(field_o));

    assert_plain_boundary_R4_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eof_o && $past(!rs_on)) |-> sof_o);

    assert_early_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vs_rise_i && rs_on) |=> sof_o && (line_o == '0));

    assert_park_no_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eof_o && $past(rs_on) && !$past(vs_rise_i)) |-> !sof_o);

endmodule

bind fct_field_timer fct_field_timer_chk #(
    .LONG_525 (LONG_525),  .SHORT_525(SHORT_525),
    .LONG_625 (LONG_625),  .SHORT_625(SHORT_625),
    .LINE_W   (LINE_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pix_en_i    (pix_en_i),
    .resync_en_i (resync_en_i),
    .tmode_i     (tmode_i),
    .std625_i    (std625_i),
    .vs_rise_i   (vs_rise),
    .line_o      (line_o),
    .field_o     (field_o),
    .sof_o       (sof_o),
    .eof_o       (eof_o)
);

// File: tb/fct_field_timer_bench.sv
// Bench: sweeps standard, mode, enable and pixel-enable gaps on a reduced line and field size,
// then runs directed early-sync and late-sync scenarios.
module fct_field_timer_bench;

    localparam int PIX  = 3;
    localparam int L525 = 6;
    localparam int S525 = 5;
    localparam int L625 = 8;
    localparam int S625 = 7;
    localparam int LW   = $clog2(L625 + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_en = 1'b0;
    logic          vsync = 1'b0;
    logic          ren = 1'b0;
    logic          std625 = 1'b0;
    logic [1:0]    tmode = 2'b00;
    logic [LW-1:0] line;
    logic          field, sof, eof;
    int            vecs = 0;
    int            errs = 0;

    always #10 clk = ~clk;

    fct_field_timer #(
        .PIX_525(PIX), .PIX_625(PIX),
        .LONG_525(L525), .SHORT_525(S525), .LONG_625(L625), .SHORT_625(S625)
    ) u_fct_field_timer (
        .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pix_en), .vsync_i(vsync),
        .resync_en_i(ren), .tmode_i(tmode), .std625_i(std625),
        .line_o(line), .field_o(field), .sof_o(sof), .eof_o(eof)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int got, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) step;
        rst_n = 1'b1;
        chk(line == 0,  "R1", "reset line",  int'(line),  0);
        chk(field == 0, "R1", "reset field", int'(field), 0);
        chk(sof == 0,   "R1", "reset sof",   int'(sof),   0);
        chk(eof == 0,   "R1", "reset eof",   int'(eof),   0);
    endtask

    // Position of line-period L in the field sequence; with parking each field lasts twice as long.
    function automatic void locate(input int L, input bit rs, input int lg, input int sh,
                                   output int f, output int q, output int len);
        int f0 = rs ? 2*lg : lg;
        int f1 = rs ? 2*sh : sh;
        int p  = L % (f0 + f1);
        if (p < f0) begin f = 0; q = p;      len = lg; end
        else        begin f = 1; q = p - f0; len = sh; end
    endfunction

    task automatic run_cfg(input bit s, input logic [1:0] m, input bit r, input bit gap);
        int lg = s ? L625 : L525;
        int sh = s ? S625 : S525;
        bit rs = r && (m != 2'b00);
        string tag = rs ? "R8" : (r ? "R5" : "R4");
        int k = 0;
        std625 = s; tmode = m; ren = r; vsync = 1'b0; pix_en = 1'b0;
        do_reset;
        for (int c = 0; c < 260; c++) begin
            bit en_now = gap ? (c % 3 != 2) : 1'b1;
            int L, f, q, len, fp, qp, lp, exp_line;
            bit evt, sof_e, eof_e;
            pix_en = en_now;
            vsync  = !rs && ((c % 29) < 4);
            step;
            if (en_now) k++;
            L   = k / PIX;
            evt = en_now && (k % PIX == 0);
            locate(L, rs, lg, sh, f, q, len);
            exp_line = (q < len) ? q : len - 1;
            sof_e = evt && (q == 0);
            eof_e = 1'b0;
            if (evt) begin
                locate(L - 1, rs, lg, sh, fp, qp, lp);
                eof_e = (qp == lp - 1);
            end
            chk(int'(line) == exp_line, gap ? "R2" : "R3", "line", int'(line), exp_line);
            chk(int'(field) == f, "R3", "field", int'(field), f);
            chk(sof == sof_e, tag, "sof", int'(sof), int'(sof_e));
            chk(eof == eof_e, tag, "eof", int'(eof), int'(eof_e));
        end
    endtask

    initial begin
        // Sweep: every standard, mode, enable and gap pattern.
        for (int s = 0; s < 2; s++)
            for (int m = 0; m < 4; m++)
                for (int r = 0; r < 2; r++)
                    for (int g = 0; g < 2; g++)
                        run_cfg(s[0], m[1:0], r[0], g[0]);

        // R6: early sync in mid-field restarts the field three edges after sampling.
        std625 = 1'b0; tmode = 2'b01; ren = 1'b1; vsync = 1'b0; pix_en = 1'b1;
        do_reset;
        repeat (2*PIX + 1) step;
        vsync = 1'b1;
        step; step;
        chk(line == 3 && sof == 0, "R6", "line before restart", int'(line), 3);
        step;
        chk(line == 0,  "R6", "restart line",  int'(line),  0);
        chk(field == 1, "R6", "restart field", int'(field), 1);
        chk(sof == 1,   "R6", "restart sof",   int'(sof),   1);
        chk(eof == 0,   "R6", "restart eof",   int'(eof),   0);
        vsync = 1'b0;
        repeat (PIX) step;
        chk(line == 1, "R6", "pixel phase restarted", int'(line), 1);

        // R7: late sync, so the counter parks on the last line until the sync edge.
        begin
            int nsof = 0;
            tmode = 2'b10; ren = 1'b1; vsync = 1'b0;
            do_reset;
            repeat (L525*PIX) step;
            chk(eof == 1,        "R7", "eof at count end", int'(eof),  1);
            chk(sof == 0,        "R7", "no sof at count end", int'(sof), 0);
            chk(line == L525-1,  "R7", "park line", int'(line), L525-1);
            for (int i = 0; i < 2*PIX; i++) begin
                step;
                nsof += int'(sof);
                chk(line == L525-1 && field == 0, "R7", "parked line", int'(line), L525-1);
            end
            vsync = 1'b1;
            for (int i = 0; i < 3; i++) begin
                step;
                nsof += int'(sof);
            end
            chk(sof == 1 && line == 0, "R7", "sof on late sync", int'(sof), 1);
            chk(field == 1, "R7", "field after late sync", int'(field), 1);
            chk(nsof == 1, "R9", "single field start", nsof, 1);
            vsync = 1'b0;
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errs++;
        $display("FAIL R2 watchdog: got running expected done (%0d, %0d)", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule